// File: doc/BRIEF.md
# Mailbox Ownership Poll and Response Validator

This block sits on the requester side of a small shared mailbox. The mailbox holds eight 32-bit words, and the last word is the control word. After a request has been written, the block polls that control word through a simple register-read port until the requester owns the mailbox again. It then reads the word a second time and checks the responder's reply against the message kind and the highest version the caller accepts.

Each job ends with a one-cycle `done` pulse. Exactly one verdict is raised with it: success, timeout or protocol error. A protocol error that comes from a nonzero status byte also raises an operation-failure flag.

Between polls the block waits a bounded number of whole cycles. That wait replaces a sleep of about a millisecond. The retry limit and both wait bounds are parameters.

Top module: `mbox_resp_checker`

## Requirements
- R1: A `start` pulse seen while idle latches `exp_kind`, `max_ver` and `reset_expected`. In the next cycle the block raises `rd_req` for exactly one cycle with `rd_addr` = 7, the index of the last mailbox word.
- R2: A poll response whose bit 31 is 0 means the requester owns the mailbox, and polling stops. In the cycle after that response the block issues one further read of word 7. All header checks use this second sample.
- R3: A poll response whose bit 31 is 1 counts as one unsuccessful poll. After `MAX_POLLS` unsuccessful polls the job ends with `timeout`. If ownership is seen on the last allowed read, the job proceeds as in R2 and no timeout is raised.
- R4: The k-th unsuccessful poll (k counted from 0 within a job) is followed by WAIT_MIN + (k mod (WAIT_MAX − WAIT_MIN + 1)) idle cycles. Each count is taken between the response cycle and the next `rd_req`.
- R5: When `reset_expected` was latched, a read of 32'hFFFFFFFF, either on a poll or on the second sample, ends the job with `ok` and no header checks. Without the flag, that value is treated as a busy poll because its bit 31 is set.
- R6: The second sample is a protocol error if its kind field [2:0] differs from `exp_kind`, if its version field [5:3] is greater than `max_ver`, or if its direction bit [7] is not 1. A version lower than or equal to `max_ver` is accepted. Bit 31 of the second sample is not checked.
- R7: A second sample that passes R6 but has a nonzero status byte [15:8] raises `proto_err` together with `op_fail`. When the status byte is zero, the job ends with `ok`.
- R8: `done` is high for one cycle, the cycle after the response that decides the job. With it, exactly one of `ok`, `timeout` and `proto_err` is high. All result outputs are 0 at other times and after reset.
- R9: A `start` pulse while a job is in progress is ignored, including any new values on the expectation inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a job (honoured only when idle) |
| exp_kind | input | 3 | Expected message kind of the reply |
| max_ver | input | 3 | Highest reply version accepted |
| reset_expected | input | 1 | The all-ones pattern counts as success |
| rd_req | output | 1 | One-cycle read request |
| rd_addr | output | 3 | Word index of the read (always the control word) |
| rd_valid | input | 1 | Read data is present this cycle |
| rd_data | input | 32 | Read data |
| done | output | 1 | One-cycle end-of-job pulse |
| ok | output | 1 | Job succeeded (valid with done) |
| timeout | output | 1 | Retry limit reached (valid with done) |
| proto_err | output | 1 | Reply rejected (valid with done) |
| op_fail | output | 1 | Rejection caused by nonzero status (valid with done) |

## Verification
Some single reads carry two conditions at once, and the bench aims at those cases.

- **All-ones read.** It is both a "responder still owns it" poll and a reset-success pattern. It is run with and without the reset flag. The bench expects an immediate `ok` in the first case and continued polling ending in `timeout` in the second.
- **Ownership on the last allowed read.** Here the retry limit and ownership fall on the same read. Ownership must win, so the bench expects a second read and no timeout.
- **Re-read disagrees with the poll.** The second sample may carry a different header than the poll that granted ownership. The verdict must follow the second sample.

A behavioural reference in the bench predicts `rd_req`, `done` and every verdict bit, and compares them on each cycle of every job.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    localparam int unsigned WORD_W = 32;

    // Control word layout; the responder decodes these positions.
    typedef struct packed {
        logic       owner_far;   // [31] 1: responder owns the mailbox
        logic [5:0] rsvd_hi;     // [30:25]
        logic       reset_req;   // [24]
        logic [7:0] rsvd_mid;    // [23:16]
        logic [7:0] status;      // [15:8] 0: operation succeeded
        logic       dir_resp;    // [7] 1: reply direction
        logic       rsvd_lo;     // [6]
        logic [2:0] version;     // [5:3]
        logic [2:0] kind;        // [2:0]
    } ctrl_word_t;

    typedef struct packed {
        logic [2:0] kind;
        logic [2:0] max_ver;
        logic       reset_ok;
    } expect_t;

    typedef enum logic [1:0] {
        VERD_OK,
        VERD_TIMEOUT,
        VERD_PROTO,
        VERD_OPFAIL
    } verdict_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_POLL_REQ,
        ST_POLL_WAIT,
        ST_BACKOFF,
        ST_HDR_REQ,
        ST_HDR_WAIT,
        ST_FINISH
    } state_e;

    function automatic logic is_reset_pattern(logic [WORD_W-1:0] w);
        return &w;
    endfunction

    function automatic verdict_e judge_reply(ctrl_word_t w, expect_t e);
        if (w.kind != e.kind || w.version > e.max_ver || !w.dir_resp)
            return VERD_PROTO;
        if (w.status != 8'd0)
            return VERD_OPFAIL;
        return VERD_OK;
    endfunction

endpackage

// File: rtl/mbox_hdr_judge.sv
module mbox_hdr_judge
    import mbox_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  expect_t           expect_q,
    output logic              owned,
    output logic              reset_hit,
    output verdict_e          verdict
);
    ctrl_word_t cw;

    always_comb begin
        cw        = ctrl_word_t'(word);
        owned     = ~cw.owner_far;
        reset_hit = expect_q.reset_ok & is_reset_pattern(word);
        verdict   = judge_reply(cw, expect_q);
    end
endmodule

// File: rtl/mbox_backoff.sv
module mbox_backoff #(
    parameter int unsigned WAIT_MIN = 100,
    parameter int unsigned WAIT_MAX = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic load,
    output logic expired
);
    localparam int unsigned SPAN  = WAIT_MAX - WAIT_MIN + 1;
    localparam int unsigned CNT_W = $clog2(WAIT_MAX + 1);
    localparam int unsigned PH_W  = (SPAN > 1) ? $clog2(SPAN) : 1;
    localparam logic [PH_W-1:0]  PH_LAST = PH_W'(SPAN - 1);
    localparam logic [CNT_W-1:0] BASE    = CNT_W'(WAIT_MIN - 1);

    logic [CNT_W-1:0] cnt;
    logic [PH_W-1:0]  phase;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt   <= '0;
            phase <= '0;
        end else if (load) begin
            cnt   <= BASE + CNT_W'(phase);
            phase <= (phase == PH_LAST) ? '0 : phase + 1'b1;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

    AST_WAIT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        load && !clear |=> (cnt >= BASE) && (cnt <= CNT_W'(WAIT_MAX - 1))); // R4
endmodule

// File: rtl/mbox_poll_count.sv
module mbox_poll_count #(
    parameter int unsigned MAX_POLLS = 20000
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic bump,
    output logic last
);
    localparam int unsigned CW = $clog2(MAX_POLLS + 1);
    localparam logic [CW-1:0] LAST_IDX = CW'(MAX_POLLS - 1);

    logic [CW-1:0] fails;

    always_ff @(posedge clk) begin
        if (rst || clear)
            fails <= '0;
        else if (bump)
            fails <= fails + 1'b1;
    end

    assign last = (fails == LAST_IDX);

    AST_COUNT_BELOW_LIMIT: assert property (@(posedge clk) disable iff (rst)
        fails < CW'(MAX_POLLS)); // R3
endmodule

// File: rtl/mbox_resp_checker.sv
module mbox_resp_checker
    import mbox_pkg::*;
#(
    parameter int unsigned NUM_WORDS = 8,
    parameter int unsigned MAX_POLLS = 20000,
    parameter int unsigned WAIT_MIN  = 100,
    parameter int unsigned WAIT_MAX  = 200,
    localparam int unsigned IDX_W    = $clog2(NUM_WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [2:0]        exp_kind,
    input  logic [2:0]        max_ver,
    input  logic              reset_expected,
    output logic              rd_req,
    output logic [IDX_W-1:0]  rd_addr,
    input  logic              rd_valid,
    input  logic [WORD_W-1:0] rd_data,
    output logic              done,
    output logic              ok,
    output logic              timeout,
    output logic              proto_err,
    output logic              op_fail
);
    localparam logic [IDX_W-1:0] CTRL_IDX = IDX_W'(NUM_WORDS - 1);

    state_e   state, state_n;
    verdict_e verd_q, verd_n;
    expect_t  exp_q;
    logic     latch, clr, bump, load;
    logic     owned, reset_hit, last, expired;
    verdict_e verdict;

    mbox_hdr_judge u_judge (
        .word     (rd_data),
        .expect_q (exp_q),
        .owned    (owned),
        .reset_hit(reset_hit),
        .verdict  (verdict)
    );

    mbox_poll_count #(.MAX_POLLS(MAX_POLLS)) u_count (
        .clk  (clk),
        .rst  (rst),
        .clear(clr),
        .bump (bump),
        .last (last)
    );

    mbox_backoff #(.WAIT_MIN(WAIT_MIN), .WAIT_MAX(WAIT_MAX)) u_backoff (
        .clk    (clk),
        .rst    (rst),
        .clear  (clr),
        .load   (load),
        .expired(expired)
    );

    always_comb begin
        state_n = state;
        verd_n  = verd_q;
        latch   = 1'b0;
        clr     = 1'b0;
        bump    = 1'b0;
        load    = 1'b0;
        case (state)
            ST_IDLE: if (start) begin
                state_n = ST_POLL_REQ;
                latch   = 1'b1;
                clr     = 1'b1;
            end
            ST_POLL_REQ:  state_n = ST_POLL_WAIT;
            ST_POLL_WAIT: if (rd_valid) begin
                if (reset_hit) begin
                    verd_n  = VERD_OK;
                    state_n = ST_FINISH;
                end else if (owned) begin
                    state_n = ST_HDR_REQ;
                end else if (last) begin
                    verd_n  = VERD_TIMEOUT;
                    state_n = ST_FINISH;
                end else begin
                    bump    = 1'b1;
                    load    = 1'b1;
                    state_n = ST_BACKOFF;
                end
            end
            ST_BACKOFF:  if (expired) state_n = ST_POLL_REQ;
            ST_HDR_REQ:  state_n = ST_HDR_WAIT;
            ST_HDR_WAIT: if (rd_valid) begin
                verd_n  = reset_hit ? VERD_OK : verdict;
                state_n = ST_FINISH;
            end
            ST_FINISH:   state_n = ST_IDLE;
            default:     state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            verd_q <= VERD_OK;
            exp_q  <= '0;
        end else begin
            state  <= state_n;
            verd_q <= verd_n;
            if (latch)
                exp_q <= '{kind: exp_kind, max_ver: max_ver, reset_ok: reset_expected};
        end
    end

    always_comb begin
        rd_req    = (state == ST_POLL_REQ) || (state == ST_HDR_REQ);
        rd_addr   = CTRL_IDX;
        done      = (state == ST_FINISH);
        ok        = done && (verd_q == VERD_OK);
        timeout   = done && (verd_q == VERD_TIMEOUT);
        proto_err = done && ((verd_q == VERD_PROTO) || (verd_q == VERD_OPFAIL));
        op_fail   = done && (verd_q == VERD_OPFAIL);
    end

    AST_REQ_AFTER_START: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) && start |=> rd_req); // R1
    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> !rd_req); // R1
    AST_REREAD_ON_OWN: assert property (@(posedge clk) disable iff (rst)
        (state == ST_POLL_WAIT) && rd_valid && !rd_data[31] |=> rd_req); // R2
    AST_TIMEOUT_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
        timeout |-> $past(rd_data[31])); // R3
    AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (rst)
        done |-> $countones({ok, timeout, proto_err}) == 1); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8
    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE) && start |=> $stable(exp_q)); // R9
endmodule

// File: tb/mbox_resp_checker_tb_top.sv
`timescale 1ns/1ps
module mbox_resp_checker_tb_top;
    localparam int MAXP = 5;
    localparam int WMIN = 2;
    localparam int WMAX = 4;
    localparam int SPAN = WMAX - WMIN + 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  exp_kind = '0;
    logic [2:0]  max_ver = '0;
    logic        reset_expected = 1'b0;
    logic        rd_valid = 1'b0;
    logic [31:0] rd_data = '0;
    logic        rd_req, done, ok, timeout, proto_err, op_fail;
    logic [2:0]  rd_addr;

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;
    logic [31:0] rq[$];

    always #2.5 clk = ~clk;

    mbox_resp_checker #(
        .NUM_WORDS(8), .MAX_POLLS(MAXP), .WAIT_MIN(WMIN), .WAIT_MAX(WMAX)
    ) dut_i (
        .clk(clk), .rst(rst), .start(start), .exp_kind(exp_kind),
        .max_ver(max_ver), .reset_expected(reset_expected),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid),
        .rd_data(rd_data), .done(done), .ok(ok), .timeout(timeout),
        .proto_err(proto_err), .op_fail(op_fail)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_fail++;
            $display("FAIL R8 watchdog: ran %0d cycles, expected fewer than 20000", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    function automatic logic [31:0] mk(bit far, bit [7:0] st, bit dir,
                                       bit [2:0] ver, bit [2:0] kind);
        return {far, 7'd0, 8'd0, st, dir, 1'b0, ver, kind};
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic expect_cycle(string tag, bit req, bit dn, bit e_ok,
                                bit e_tmo, bit e_pe, bit e_of);
        n_run++;
        if (rd_req !== req || done !== dn || ok !== e_ok || timeout !== e_tmo ||
            proto_err !== e_pe || op_fail !== e_of || (req && rd_addr !== 3'd7)) begin
            n_fail++;
            $display("FAIL %s: req,addr,done,ok,tmo,pe,of = %b,%0d,%b,%b,%b,%b,%b expected %b,7,%b,%b,%b,%b,%b",
                     tag, rd_req, rd_addr, done, ok, timeout, proto_err, op_fail,
                     req, dn, e_ok, e_tmo, e_pe, e_of);
        end
    endtask

    // Reference: walks the job read by read from the requirements.
    task automatic run_case(string tag, bit [2:0] et, bit [2:0] mv, bit rx,
                            int lat, bit noisy);
        int k = 0;
        int idx = 0;
        int res = 0;   // 0 ok, 1 timeout, 2 protocol, 3 op failure
        bit in_hdr = 0;
        bit fin = 0;
        logic [31:0] d;
        start = 1'b1; exp_kind = et; max_ver = mv; reset_expected = rx;
        expect_cycle(tag, 0, 0, 0, 0, 0, 0);
        tick();
        start = noisy;
        if (noisy) begin
            exp_kind = ~et; max_ver = ~mv; reset_expected = ~rx;
        end
        while (!fin) begin
            expect_cycle(tag, 1, 0, 0, 0, 0, 0);
            tick();
            for (int i = 1; i < lat; i++) begin
                expect_cycle(tag, 0, 0, 0, 0, 0, 0);
                tick();
            end
            d = rq[(idx < rq.size()) ? idx : rq.size() - 1];
            idx++;
            rd_valid = 1'b1; rd_data = d;
            expect_cycle(tag, 0, 0, 0, 0, 0, 0);
            tick();
            rd_valid = 1'b0; rd_data = '0;
            if (!in_hdr) begin
                if (rx && d == 32'hFFFF_FFFF) begin
                    res = 0; fin = 1;
                end else if (!d[31]) begin
                    in_hdr = 1;
                end else begin
                    k++;
                    if (k == MAXP) begin
                        res = 1; fin = 1;
                    end else begin
                        for (int i = 0; i < WMIN + ((k - 1) % SPAN); i++) begin
                            expect_cycle(tag, 0, 0, 0, 0, 0, 0);
                            tick();
                        end
                    end
                end
            end else begin
                fin = 1;
                if (rx && d == 32'hFFFF_FFFF) res = 0;
                else if (d[2:0] != et || d[5:3] > mv || !d[7]) res = 2;
                else if (d[15:8] != 8'd0) res = 3;
                else res = 0;
            end
        end
        start = 1'b0;
        expect_cycle(tag, 0, 1, res == 0, res == 1, res >= 2, res == 3);
        tick();
        expect_cycle(tag, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (3) tick();
        expect_cycle("R8 reset state", 0, 0, 0, 0, 0, 0);
        rst = 1'b0;
        tick();
        expect_cycle("R8 idle after reset", 0, 0, 0, 0, 0, 0);

        // R1 R2 owned at once, valid reply
        rq = {}; rq.push_back(mk(0, 0, 1, 0, 1));
        run_case("R1 R2 immediate ownership", 3'd1, 3'd0, 0, 1, 0);

        // R6 kind mismatch
        rq = {}; rq.push_back(mk(0, 0, 1, 0, 2));
        run_case("R6 kind mismatch", 3'd1, 3'd0, 0, 2, 0);

        // R6 version above limit, then below limit accepted
        rq = {}; rq.push_back(mk(0, 0, 1, 3, 2));
        run_case("R6 version too high", 3'd2, 3'd2, 0, 1, 0);
        rq = {}; rq.push_back(mk(0, 0, 1, 1, 2));
        run_case("R6 lower version accepted", 3'd2, 3'd2, 0, 1, 0);

        // R6 wrong direction
        rq = {}; rq.push_back(mk(0, 0, 0, 0, 1));
        run_case("R6 direction not reply", 3'd1, 3'd0, 0, 1, 0);

        // R7 nonzero status
        rq = {}; rq.push_back(mk(0, 8'h05, 1, 0, 1));
        run_case("R7 status failure", 3'd1, 3'd0, 0, 1, 0);

        // R3 R4 busy twice then owned, longer latency
        rq = {}; rq.push_back(mk(1, 0, 0, 0, 0)); rq.push_back(mk(1, 0, 0, 0, 0));
        rq.push_back(mk(0, 0, 1, 0, 2)); rq.push_back(mk(0, 0, 1, 0, 2));
        run_case("R3 R4 busy then owned", 3'd2, 3'd0, 0, 3, 0);

        // R3 R4 always busy: timeout
        rq = {}; rq.push_back(mk(1, 0, 1, 0, 1));
        run_case("R3 R4 timeout", 3'd1, 3'd0, 0, 1, 0);

        // R3 ownership on last allowed read wins over the limit
        rq = {};
        for (int i = 0; i < MAXP - 1; i++) rq.push_back(mk(1, 0, 0, 0, 0));
        rq.push_back(mk(0, 0, 1, 0, 4)); rq.push_back(mk(0, 0, 1, 0, 4));
        run_case("R3 owned on last poll", 3'd4, 3'd0, 0, 1, 0);

        // R5 reset pattern with flag, on the poll
        rq = {}; rq.push_back(32'hFFFF_FFFF);
        run_case("R5 reset pattern on poll", 3'd1, 3'd0, 1, 1, 0);

        // R5 reset pattern with flag, on the second sample
        rq = {}; rq.push_back(mk(0, 0, 1, 0, 3)); rq.push_back(32'hFFFF_FFFF);
        run_case("R5 reset pattern on re-read", 3'd1, 3'd0, 1, 2, 0);

        // R5 reset pattern without flag is a busy poll
        rq = {}; rq.push_back(32'hFFFF_FFFF);
        run_case("R5 all-ones without flag", 3'd1, 3'd0, 0, 1, 0);

        // R2 second sample differs from the poll sample
        rq = {}; rq.push_back(mk(0, 0, 1, 0, 1)); rq.push_back(mk(0, 0, 1, 0, 6));
        run_case("R2 verdict from second sample", 3'd1, 3'd0, 0, 1, 0);

        // R6 owner bit of second sample not checked
        rq = {}; rq.push_back(mk(0, 0, 1, 0, 5)); rq.push_back(mk(1, 0, 1, 0, 5));
        run_case("R6 owner bit ignored on re-read", 3'd5, 3'd0, 0, 1, 0);

        // R9 start held high with other expectations while busy
        rq = {}; rq.push_back(mk(1, 0, 0, 0, 0)); rq.push_back(mk(0, 0, 1, 2, 3));
        run_case("R9 busy start ignored", 3'd3, 3'd2, 0, 2, 1);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule